// File: doc/BRIEF.md
# Serial LED Shift-Chain Controller

This block drives an external serial-in, parallel-out shift register with an output latch, so that a row of LEDs shows on-chip state. It sends a frame over and over. The frame carries three signals: a serial clock, a serial data line, and a latch strobe that moves the shifted pattern onto the LED outputs after the last bit. A frame is built at run time from up to four pieces, always in this order:

1. A header of 0 to 32 user-defined bits.
2. One formatted status field for each enabled port, lowest port first.
3. An optional 17-bit debug word.
4. A trailer of 0 to 32 user-defined bits.

Every piece is sent least significant bit first.

The serial clock comes from the system clock through a programmable divider. One serial-clock phase is the phase setting times a fixed unit of system clocks. A full serial-clock period is two phases. The header and trailer data words live inside the block, and each can be written, bit-set or bit-cleared. All other settings come in as inputs from the register file. Per-port formatted fields and the debug word also come in as inputs. The block raises a one-cycle frame-done pulse as each latch strobe ends. The status formatter uses this pulse as its update tick.

Top module: `led_chain_ctrl`

## Requirements
- R1: During and right after reset, `led_sclk`, `led_sdat`, `led_latch` and `frame_done` are all 0.
- R2: Each half of the serial clock (high time and low time) lasts `cfg_phase`×PH_UNIT system clocks. A `cfg_phase` of 0 acts as 1.
- R3: `led_sdat` changes only while `led_sclk` is low, that is on the falling edges. It is stable whenever `led_sclk` is high, so the external register samples it on the rising edge.
- R4: The frame opens with `hdr_cnt` header bits, taken from header word bits 0, 1, 2 and so on. A count above 32 sends 32 bits.
- R5: Next come the status fields of the ports whose `prt_en` bit is 1, from port 0 up to port 7. Each field is `fld_len` bits of that port's slice `port_fld[8p+7:8p]`, bit 0 first. An `fld_len` above 8 sends 8 bits.
- R6: When `dbg_en` is 1, the 17 bits of `dbg_word` follow the port section, bit 0 first.
- R7: The frame closes with `trl_cnt` trailer bits, taken from the trailer word under the same rules as R4.
- R8: After the last falling edge of a frame, `led_latch` is high for two phases while `led_sclk` stays low. `frame_done` pulses for one cycle in the cycle in which `led_latch` falls.
- R9: When `cfg_pol` is 1, every frame bit on `led_sdat` is inverted. When it is 0, the bits are sent unchanged (active-high LEDs).
- R10: Clearing `cfg_en` lets the frame in flight finish, including its latch strobe. After that, no serial clock edge and no latch strobe appear until `cfg_en` returns.
- R11: For the word chosen by `udd_sel` (0 = header, 1 = trailer):
  - `udd_wr` replaces the word with `udd_wdata`.
  - `udd_set` ORs `udd_wdata` into the word.
  - `udd_clr` clears the bits that are 1 in `udd_wdata`.
  - If several of these are asserted in the same cycle, the priority order is write, then set, then clear.
  - Both words reset to 0.
- R12: A frame with no bits (header and trailer counts 0, no enabled ports or zero field length, debug off) still produces the latch strobe and `frame_done`, with no serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Master enable of the shift chain |
| cfg_pol | input | 1 | 1 = invert serial data for active-low LEDs |
| cfg_phase | input | 7 | Serial clock phase length in PH_UNIT clocks |
| hdr_cnt | input | 6 | Header bit count (clamped to 32) |
| trl_cnt | input | 6 | Trailer bit count (clamped to 32) |
| udd_sel | input | 1 | Word targeted by a data access: 0 header, 1 trailer |
| udd_wr | input | 1 | Replace the selected word |
| udd_set | input | 1 | Bitwise set into the selected word |
| udd_clr | input | 1 | Bitwise clear of the selected word |
| udd_wdata | input | 32 | Data, set mask or clear mask |
| prt_en | input | 8 | Per-port status enable |
| fld_len | input | 4 | Bits sent from each enabled port field (clamped to 8) |
| port_fld | input | 64 | Formatted status, 8 bits per port, port 0 in bits 7:0 |
| dbg_en | input | 1 | Append the debug word |
| dbg_word | input | 17 | Debug data |
| led_sclk | output | 1 | Serial clock to the shift register |
| led_sdat | output | 1 | Serial data |
| led_latch | output | 1 | Parallel latch strobe |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The bench goes after the segment joins, where a design can easily drop or repeat a bit:
- when a disabled port sits between two enabled ones;
- when the debug word switches on and off;
- when a count is zero, or above 32.

A wrong clamp shows up as a frame of the wrong length. Sending the pieces in the wrong bit order shows up as mirrored patterns. An empty frame checks that the latch still pulses instead of the sequencer hanging. Clearing the enable mid-frame shows whether a design truncates the frame or keeps clocking. The bench also checks that phase 0 gives the minimum phase rather than a wrap to the longest one.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } chain_state_e;
endpackage

// File: rtl/led_phase_div.sv
module led_phase_div #(
  parameter int PHASE_W = 7,
  parameter int PH_UNIT = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase,
  output logic               tick
);
  localparam int CNT_W = PHASE_W + $clog2(PH_UNIT + 1);

  logic [PHASE_W-1:0] eff;
  logic [CNT_W-1:0]   lim;
  logic [CNT_W-1:0]   cnt;

  always_comb begin
    eff = (phase == '0) ? PHASE_W'(1) : phase;
    lim = CNT_W'(eff) * CNT_W'(PH_UNIT) - CNT_W'(1);
  end

  // ">=" keeps a shrinking phase from waiting for a counter wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/led_udd_reg.sv
module led_udd_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         set,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (wr)  q <= wdata;
    else if (set) q <= q | wdata;
    else if (clr) q <= q & ~wdata;
  end
endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
  import led_chain_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int FLD_W = 8,
  parameter int UDD_W = 32,
  parameter int DBG_W = 17,
  parameter int CNT_W = 6,
  parameter int FL_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   en,
  input  logic                   pol,
  input  logic [CNT_W-1:0]       hdr_cnt,
  input  logic [CNT_W-1:0]       trl_cnt,
  input  logic [UDD_W-1:0]       hdr_dat,
  input  logic [UDD_W-1:0]       trl_dat,
  input  logic [NPORT-1:0]       prt_en,
  input  logic [FL_W-1:0]        fld_len,
  input  logic [NPORT*FLD_W-1:0] port_fld,
  input  logic                   dbg_en,
  input  logic [DBG_W-1:0]       dbg_word,
  output logic                   sclk,
  output logic                   sdat,
  output logic                   latch,
  output logic                   done
);
  localparam int NSLOT   = NPORT + 3;
  localparam int SLOT_W  = $clog2(NSLOT + 1);
  localparam int NSLOT_P = 2 ** SLOT_W;
  localparam int LEN_W   = $clog2(UDD_W + DBG_W + FLD_W + 1);
  localparam int WORD_N  = 2 ** LEN_W;

  chain_state_e state;
  logic [SLOT_W-1:0] cur_slot, first_slot, after_slot;
  logic [LEN_W-1:0]  cur_idx, nxt_idx;
  logic              first_ok, after_ok, more_in_slot, lat_half;

  // Frame shape is frozen at frame start; live values feed the start decision
  logic [CNT_W-1:0] s_hdr, s_trl, hdr_cl, trl_cl, m_hdr, m_trl;
  logic [FL_W-1:0]  s_fld, fld_cl, m_fld;
  logic [NPORT-1:0] s_prt, m_prt;
  logic             s_dbg, m_dbg, use_snap;

  logic [LEN_W-1:0]  slen  [NSLOT_P];
  logic [WORD_N-1:0] sword [NSLOT_P];

  always_comb begin
    hdr_cl   = (hdr_cnt > CNT_W'(UDD_W)) ? CNT_W'(UDD_W) : hdr_cnt;
    trl_cl   = (trl_cnt > CNT_W'(UDD_W)) ? CNT_W'(UDD_W) : trl_cnt;
    fld_cl   = (fld_len > FL_W'(FLD_W)) ? FL_W'(FLD_W) : fld_len;
    use_snap = (state == ST_SHIFT);
    m_hdr    = use_snap ? s_hdr : hdr_cl;
    m_trl    = use_snap ? s_trl : trl_cl;
    m_fld    = use_snap ? s_fld : fld_cl;
    m_prt    = use_snap ? s_prt : prt_en;
    m_dbg    = use_snap ? s_dbg : dbg_en;
  end

  // Slot 0 header, slots 1..NPORT ports, then debug, then trailer
  always_comb begin
    for (int s = 0; s < NSLOT_P; s++) begin
      slen[s]  = '0;
      sword[s] = '0;
    end
    slen[0]  = LEN_W'(m_hdr);
    sword[0] = WORD_N'(hdr_dat);
    for (int p = 0; p < NPORT; p++) begin
      slen[p+1]  = m_prt[p] ? LEN_W'(m_fld) : '0;
      sword[p+1] = WORD_N'(port_fld[p*FLD_W +: FLD_W]);
    end
    slen[NPORT+1]  = m_dbg ? LEN_W'(DBG_W) : '0;
    sword[NPORT+1] = WORD_N'(dbg_word);
    slen[NPORT+2]  = LEN_W'(m_trl);
    sword[NPORT+2] = WORD_N'(trl_dat);
  end

  always_comb begin
    first_ok   = 1'b0;
    first_slot = '0;
    after_ok   = 1'b0;
    after_slot = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (slen[s] != '0) begin
        first_ok   = 1'b1;
        first_slot = SLOT_W'(s);
      end
      if (slen[s] != '0 && SLOT_W'(s) > cur_slot) begin
        after_ok   = 1'b1;
        after_slot = SLOT_W'(s);
      end
    end
    nxt_idx      = cur_idx + LEN_W'(1);
    more_in_slot = ({1'b0, cur_idx} + 1'b1) < {1'b0, slen[cur_slot]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sclk     <= 1'b0;
      sdat     <= 1'b0;
      latch    <= 1'b0;
      done     <= 1'b0;
      lat_half <= 1'b0;
      cur_slot <= '0;
      cur_idx  <= '0;
      s_hdr    <= '0;
      s_trl    <= '0;
      s_fld    <= '0;
      s_prt    <= '0;
      s_dbg    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          sdat <= pol;
          if (tick && en) begin
            s_hdr <= hdr_cl;
            s_trl <= trl_cl;
            s_fld <= fld_cl;
            s_prt <= prt_en;
            s_dbg <= dbg_en;
            if (first_ok) begin
              cur_slot <= first_slot;
              cur_idx  <= '0;
              sdat     <= sword[first_slot][0] ^ pol;
              state    <= ST_SHIFT;
            end else begin
              latch    <= 1'b1;
              lat_half <= 1'b0;
              state    <= ST_LATCH;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (more_in_slot) begin
                cur_idx <= nxt_idx;
                sdat    <= sword[cur_slot][nxt_idx] ^ pol;
              end else if (after_ok) begin
                cur_slot <= after_slot;
                cur_idx  <= '0;
                sdat     <= sword[after_slot][0] ^ pol;
              end else begin
                latch    <= 1'b1;
                lat_half <= 1'b0;
                state    <= ST_LATCH;
              end
            end
          end
        end
        ST_LATCH: begin
          if (tick) begin
            if (!lat_half) begin
              lat_half <= 1'b1;
            end else begin
              latch <= 1'b0;
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl #(
  parameter int NPORT   = 8,
  parameter int FLD_W   = 8,
  parameter int UDD_W   = 32,
  parameter int DBG_W   = 17,
  parameter int PHASE_W = 7,
  parameter int PH_UNIT = 64,
  parameter int CNT_W   = $clog2(UDD_W + 1),
  parameter int FL_W    = $clog2(FLD_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_en,
  input  logic                   cfg_pol,
  input  logic [PHASE_W-1:0]     cfg_phase,
  input  logic [CNT_W-1:0]       hdr_cnt,
  input  logic [CNT_W-1:0]       trl_cnt,
  input  logic                   udd_sel,
  input  logic                   udd_wr,
  input  logic                   udd_set,
  input  logic                   udd_clr,
  input  logic [UDD_W-1:0]       udd_wdata,
  input  logic [NPORT-1:0]       prt_en,
  input  logic [FL_W-1:0]        fld_len,
  input  logic [NPORT*FLD_W-1:0] port_fld,
  input  logic                   dbg_en,
  input  logic [DBG_W-1:0]       dbg_word,
  output logic                   led_sclk,
  output logic                   led_sdat,
  output logic                   led_latch,
  output logic                   frame_done
);
  logic             ph_tick;
  logic [UDD_W-1:0] udd_q [2];

  led_phase_div #(.PHASE_W(PHASE_W), .PH_UNIT(PH_UNIT)) i_div (
    .clk(clk), .rst(rst), .phase(cfg_phase), .tick(ph_tick)
  );

  // Word 0 is the header, word 1 the trailer
  for (genvar g = 0; g < 2; g++) begin : g_udd
    led_udd_reg #(.W(UDD_W)) i_udd (
      .clk(clk), .rst(rst),
      .wr(udd_wr && (udd_sel == 1'(g))),
      .set(udd_set && (udd_sel == 1'(g))),
      .clr(udd_clr && (udd_sel == 1'(g))),
      .wdata(udd_wdata), .q(udd_q[g])
    );
  end

  led_frame_seq #(
    .NPORT(NPORT), .FLD_W(FLD_W), .UDD_W(UDD_W), .DBG_W(DBG_W),
    .CNT_W(CNT_W), .FL_W(FL_W)
  ) i_seq (
    .clk(clk), .rst(rst), .tick(ph_tick), .en(cfg_en), .pol(cfg_pol),
    .hdr_cnt(hdr_cnt), .trl_cnt(trl_cnt), .hdr_dat(udd_q[0]), .trl_dat(udd_q[1]),
    .prt_en(prt_en), .fld_len(fld_len), .port_fld(port_fld),
    .dbg_en(dbg_en), .dbg_word(dbg_word),
    .sclk(led_sclk), .sdat(led_sdat), .latch(led_latch), .done(frame_done)
  );
endmodule

// File: rtl/led_chain_chk.sv
module led_chain_chk (
  input logic clk,
  input logic rst,
  input logic led_sclk,
  input logic led_sdat,
  input logic led_latch,
  input logic frame_done
);
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    led_sclk |-> $stable(led_sdat));

  // R8
  latch_clk_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(led_latch && led_sclk));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R8
  done_at_latch_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(led_latch) |-> frame_done);

  // R8
  done_needs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(led_latch) && !led_latch);
endmodule

bind led_chain_ctrl led_chain_chk i_chain_chk (
  .clk(clk), .rst(rst), .led_sclk(led_sclk), .led_sdat(led_sdat),
  .led_latch(led_latch), .frame_done(frame_done)
);

// File: tb/test_led_chain_ctrl.sv
module test_led_chain_ctrl;
  localparam int CLK_P = 10;
  localparam int PHU   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0, cfg_pol = 1'b0;
  logic [6:0]  cfg_phase = 7'd1;
  logic [5:0]  hdr_cnt = '0, trl_cnt = '0;
  logic        udd_sel = 1'b0, udd_wr = 1'b0, udd_set = 1'b0, udd_clr = 1'b0;
  logic [31:0] udd_wdata = '0;
  logic [7:0]  prt_en = '0;
  logic [3:0]  fld_len = '0;
  logic [63:0] port_fld = '0;
  logic        dbg_en = 1'b0;
  logic [16:0] dbg_word = '0;
  logic        led_sclk, led_sdat, led_latch, frame_done;

  int errors = 0, checks = 0;
  logic [31:0] hdr_m = '0, trl_m = '0;

  led_chain_ctrl #(.PH_UNIT(PHU)) i_led_chain_ctrl (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_pol(cfg_pol), .cfg_phase(cfg_phase),
    .hdr_cnt(hdr_cnt), .trl_cnt(trl_cnt), .udd_sel(udd_sel), .udd_wr(udd_wr),
    .udd_set(udd_set), .udd_clr(udd_clr), .udd_wdata(udd_wdata), .prt_en(prt_en),
    .fld_len(fld_len), .port_fld(port_fld), .dbg_en(dbg_en), .dbg_word(dbg_word),
    .led_sclk(led_sclk), .led_sdat(led_sdat), .led_latch(led_latch),
    .frame_done(frame_done)
  );

  always #(CLK_P/2) clk = ~clk;

  // Monitor on the inactive edge
  bit cap [0:255];
  bit last [0:255];
  bit exp_b [0:255];
  int cap_n = 0, last_n = -1, exp_n = 0;
  int hi_run = 0, last_hi = 0, lat_run = 0, last_lw = 0, viol = 0, act = 0;
  logic p_sclk = 1'b0, p_latch = 1'b0, p_sdat = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (led_sclk && !p_sclk) begin
        if (cap_n < 256) cap[cap_n] = led_sdat;
        cap_n++;
      end
      if (led_sclk) hi_run++;
      if (!led_sclk && p_sclk) begin last_hi = hi_run; hi_run = 0; end
      if (led_sclk && p_sclk && led_sdat != p_sdat) viol++;
      if (led_latch && !p_latch) begin
        for (int i = 0; i < 256; i++) last[i] = cap[i];
        last_n = cap_n;
        cap_n = 0;
      end
      if (led_latch) lat_run++;
      if (!led_latch && p_latch) begin last_lw = lat_run; lat_run = 0; end
      if (led_sclk || led_latch) act++;
    end
    p_sclk = led_sclk; p_latch = led_latch; p_sdat = led_sdat;
  end

  task automatic chk(input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic calc_exp();
    int hc, tc, fl;
    exp_n = 0;
    hc = (hdr_cnt > 32) ? 32 : int'(hdr_cnt);
    tc = (trl_cnt > 32) ? 32 : int'(trl_cnt);
    fl = (fld_len > 8) ? 8 : int'(fld_len);
    for (int i = 0; i < hc; i++) begin exp_b[exp_n] = hdr_m[i] ^ cfg_pol; exp_n++; end
    for (int p = 0; p < 8; p++)
      if (prt_en[p])
        for (int i = 0; i < fl; i++) begin exp_b[exp_n] = port_fld[p*8+i] ^ cfg_pol; exp_n++; end
    if (dbg_en)
      for (int i = 0; i < 17; i++) begin exp_b[exp_n] = dbg_word[i] ^ cfg_pol; exp_n++; end
    for (int i = 0; i < tc; i++) begin exp_b[exp_n] = trl_m[i] ^ cfg_pol; exp_n++; end
  endtask

  task automatic wait_done();
    int t = 0;
    @(negedge clk);
    while (!frame_done && t < 40000) begin @(negedge clk); t++; end
    if (!frame_done) chk("R8 frame_done timeout", 0, 1);
  endtask

  task automatic check_frame(input string tag);
    int bad = -1;
    calc_exp();
    chk({tag, " length"}, last_n, exp_n);
    for (int i = 0; i < exp_n && i < 256; i++)
      if (bad < 0 && last[i] != exp_b[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: bit %0d actual=%0d expected=%0d", tag, bad, last[bad], exp_b[bad]);
    end
  endtask

  task automatic run_cfg(input string tag);
    wait_done();
    wait_done();
    check_frame(tag);
  endtask

  task automatic udd_op(input logic sel, input int op, input logic [31:0] d);
    @(negedge clk);
    udd_sel = sel; udd_wdata = d;
    udd_wr = (op == 0); udd_set = (op == 1); udd_clr = (op == 2);
    @(negedge clk);
    udd_wr = 0; udd_set = 0; udd_clr = 0;
    if (op == 0) begin if (sel) trl_m = d; else hdr_m = d; end
    else if (op == 1) begin if (sel) trl_m |= d; else hdr_m |= d; end
    else begin if (sel) trl_m &= ~d; else hdr_m &= ~d; end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1
    chk("R1 reset sclk", led_sclk, 0);
    chk("R1 reset sdat", led_sdat, 0);
    chk("R1 reset latch", led_latch, 0);
    chk("R1 reset done", frame_done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset latch", led_latch, 0);

    // R11 data words
    udd_op(0, 0, 32'hA5A5_0F0F);
    udd_op(1, 0, 32'h1234_5678);

    // R4 R5 R6 R7 directed frame with a gap between enabled ports
    hdr_cnt = 8; trl_cnt = 5; prt_en = 8'b1000_0101; fld_len = 3;
    port_fld = 64'hC3A5_0000_0000_6E96; dbg_en = 1; dbg_word = 17'h1_2A5C;
    cfg_phase = 1; cfg_en = 1;
    run_cfg("R4 R5 R6 R7 directed");
    chk("R2 phase 1 width", last_hi, PHU);
    chk("R8 latch width", last_lw, 2 * PHU);

    // R2 other phase values
    cfg_phase = 3;
    run_cfg("R2 frame at phase 3");
    chk("R2 phase 3 width", last_hi, 3 * PHU);
    chk("R8 latch width phase 3", last_lw, 6 * PHU);
    cfg_phase = 0;
    run_cfg("R2 frame at phase 0");
    chk("R2 phase 0 acts as 1", last_hi, PHU);

    // R4 R5 clamping
    hdr_cnt = 40; fld_len = 12; prt_en = 8'b0100_0010; dbg_en = 0; trl_cnt = 63;
    run_cfg("R4 R5 R7 clamp");

    // R9 polarity
    cfg_pol = 1; hdr_cnt = 12; trl_cnt = 7; dbg_en = 1;
    run_cfg("R9 inverted data");
    cfg_pol = 0;

    // R11 set and clear, priority of write over set
    udd_op(0, 1, 32'h0000_F0F0);
    udd_op(1, 2, 32'h0000_0F0F);
    @(negedge clk);
    udd_sel = 1; udd_wdata = 32'h0000_0055; udd_wr = 1; udd_set = 1; udd_clr = 1;
    @(negedge clk);
    udd_wr = 0; udd_set = 0; udd_clr = 0; trl_m = 32'h0000_0055;
    hdr_cnt = 32; trl_cnt = 32; prt_en = 0; dbg_en = 0;
    run_cfg("R11 set clear write");

    // R12 empty frame
    hdr_cnt = 0; trl_cnt = 0; prt_en = 8'hFF; fld_len = 0; dbg_en = 0; cfg_phase = 2;
    run_cfg("R12 empty frame");
    chk("R12 latch width empty", last_lw, 4 * PHU);

    // R4 R5 R6 R7 random frames
    for (int k = 0; k < 6; k++) begin
      udd_op(0, 0, $urandom);
      udd_op(1, 0, $urandom);
      hdr_cnt = 6'($urandom_range(0, 40)); trl_cnt = 6'($urandom_range(0, 40));
      prt_en = 8'($urandom); fld_len = 4'($urandom_range(0, 9));
      port_fld = {$urandom, $urandom}; dbg_en = 1'($urandom);
      dbg_word = 17'($urandom); cfg_phase = 7'($urandom_range(1, 2));
      cfg_pol = 1'($urandom);
      run_cfg("R4 R5 R6 R7 R9 random");
    end

    // R10 enable cleared mid-frame
    cfg_pol = 0; cfg_phase = 1; hdr_cnt = 20; trl_cnt = 20; prt_en = 8'h0F;
    fld_len = 6; dbg_en = 1;
    wait_done();
    repeat (30) @(negedge clk);
    cfg_en = 0;
    wait_done();
    check_frame("R10 in-flight frame completes");
    act = 0;
    repeat (400) @(negedge clk);
    chk("R10 idle after disable", act, 0);

    // R3
    chk("R3 data change while sclk high", viol, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule